// File: doc/BRIEF.md
# Power-on reset configuration sequencer

This block runs the reset sequence of a device from power-up until its software may start. It watches an active-low power-on reset input. On the clock where that input is first seen high after a long enough low period, it captures a host-enable pin, a configuration-role pin and a DLL-enable pin. The host-enable pin then chooses between two ways of configuring the device.

With the host enabled, the device stays in reset until an external host has written a 32-bit configuration word through an 8-bit write port, one byte at a time. Without the host, a fixed hardware configuration period runs. That period decides whether the device acts as configuration master or slave, and at its end the 3-bit operating-mode pins are captured. Both paths then wait for PLL lock and, if the DLL is enabled, for DLL lock. Lock is modelled by counters. After lock the hard reset output is released, and the soft reset output follows a fixed number of clocks later. Everything runs on a single clock, and a new power-on reset returns the block to its reset state on the next edge.

Top module: `rstcfg_seq`

## Requirements
- R1: On every clock edge that samples `por_n` low, the block enters its reset state. In that state `hreset_n`, `sreset_n`, `cfg_done`, `por_bad`, `cfg_master`, `host_mode`, `cfg_word` and `mode_sel` are all 0.
- R2: A `por_n` low period of fewer than 16 clock edges makes `por_bad` 1. The block then holds both resets low until `por_n` goes low again. A low period of exactly 16 edges is accepted and `por_bad` stays 0.
- R3: `host_en_pin` is sampled on the first edge that sees `por_n` high. A 1 selects host configuration (`host_mode`=1) and a 0 selects hardware configuration (`host_mode`=0). Later changes of the pin have no effect.
- R4: In host configuration, the k-th accepted write (k=0..3) of `hwr_data` with `hwr_en`=1 lands in `cfg_word[8k+7:8k]`, least significant byte first. Both resets stay low for as long as fewer than four bytes have arrived. Writes in hardware configuration, and writes after the fourth byte, leave `cfg_word` unchanged.
- R5: In hardware configuration, `cfg_master` is the inverse of `cfg_pin` as sampled at the reset release edge: a low pin means master. In host configuration `cfg_master` is 0.
- R6: Hardware configuration lasts 1024 clocks. `mode_sel` takes the `mode_pins` value present on edge 1024 after the release edge and keeps it until the next power-on reset.
- R7: `hreset_n` rises after the edge that lies 800 + 3073 + 512 clocks after the end of configuration. Configuration ends at the release edge plus 1024 in hardware configuration, and at the edge that takes the fourth byte in host configuration.
- R8: With `dll_en` sampled low at the release edge, the 3073-clock DLL wait is left out of the delay in R7.
- R9: `sreset_n` and `cfg_done` rise exactly 3 clock edges after `hreset_n` rises, and `sreset_n` is never high while `hreset_n` is low.
- R10: A power-on reset in the middle of any phase (host wait, configuration, lock wait) clears all outputs on the next edge, and a fresh sequence follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all logic |
| por_n | input | 1 | Power-on reset, active low |
| host_en_pin | input | 1 | Host configuration select, sampled at reset release |
| cfg_pin | input | 1 | Configuration role pin, low selects master |
| dll_en | input | 1 | DLL enable, sampled at reset release |
| mode_pins | input | 3 | Operating mode pins, captured at end of hardware configuration |
| hwr_en | input | 1 | Host byte write strobe to the configuration word register |
| hwr_data | input | 8 | Host write byte |
| hreset_n | output | 1 | Hard reset, active low |
| sreset_n | output | 1 | Soft reset, active low |
| cfg_word | output | 32 | Configuration word assembled from host writes |
| cfg_master | output | 1 | Device acts as configuration master |
| host_mode | output | 1 | Host configuration was selected |
| mode_sel | output | 3 | Latched operating mode |
| cfg_done | output | 1 | Reset sequence complete |
| por_bad | output | 1 | Power-on reset pulse was too short |

## Verification
The properties assume that `por_n` is low on the first clock edge, so the state register starts from a known value, and every property is switched off while `por_n` is low. The 3-clock history used for the soft reset gap therefore always falls inside a sequence that reset has already started. The stimulus drives `por_n` low from time zero and keeps every low pulse at one clock or more. All inputs change half a period away from the sampling edge. Random mode pins, write data and write spacing stay inside these limits.

// File: rtl/rstcfg_pkg.sv
package rstcfg_pkg;

    typedef enum logic [3:0] {
        ST_POR   = 4'd0,
        ST_BAD   = 4'd1,
        ST_HOST  = 4'd2,
        ST_HWCFG = 4'd3,
        ST_PLL   = 4'd4,
        ST_DLL   = 4'd5,
        ST_HHOLD = 4'd6,
        ST_SGAP  = 4'd7,
        ST_DONE  = 4'd8
    } seq_st_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rstcfg_por_filter.sv
module rstcfg_por_filter #(
    parameter int MIN_LOW = 16
) (
    input  logic clk,
    input  logic por_n,
    output logic long_enough
);
    localparam int CW = $clog2(MIN_LOW + 1);

    logic [CW-1:0] low_cnt_d, low_cnt_q;

    always_comb begin
        low_cnt_d = low_cnt_q;
        if (por_n) begin
            low_cnt_d = '0;
        end else if (low_cnt_q != CW'(MIN_LOW)) begin
            low_cnt_d = low_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        low_cnt_q <= low_cnt_d;
    end

    assign long_enough = (low_cnt_q == CW'(MIN_LOW));

endmodule

// File: rtl/rstcfg_timer.sv
module rstcfg_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/rstcfg_host_loader.sv
module rstcfg_host_loader #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     clr,
    input  logic                     accept,
    input  logic                     wr_en,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [NBYTES*BYTE_W-1:0] word,
    output logic                     last
);
    localparam int IDX_W  = $clog2(NBYTES);
    localparam int WORD_W = NBYTES * BYTE_W;

    logic [WORD_W-1:0] word_d, word_q;
    logic [IDX_W-1:0]  idx_d, idx_q;
    logic              take;

    assign take = accept && wr_en && !clr;

    always_comb begin
        word_d = word_q;
        idx_d  = idx_q;
        if (clr) begin
            word_d = '0;
            idx_d  = '0;
        end else if (take) begin
            for (int k = 0; k < NBYTES; k++) begin
                if (idx_q == IDX_W'(k)) begin
                    word_d[k*BYTE_W +: BYTE_W] = wr_data;
                end
            end
            idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        word_q <= word_d;
        idx_q  <= idx_d;
    end

    assign word = word_q;
    assign last = take && (idx_q == IDX_W'(NBYTES - 1));

endmodule

// File: rtl/rstcfg_seq.sv
module rstcfg_seq
    import rstcfg_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int NBYTES      = 4,
    parameter int MODE_W      = 3,
    parameter int MIN_POR_LOW = 16,
    parameter int CFG_CYCLES  = 1024,
    parameter int PLL_CYCLES  = 800,
    parameter int DLL_CYCLES  = 3073,
    parameter int HRST_CYCLES = 512,
    parameter int SGAP_CYCLES = 3
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     host_en_pin,
    input  logic                     cfg_pin,
    input  logic                     dll_en,
    input  logic [MODE_W-1:0]        mode_pins,
    input  logic                     hwr_en,
    input  logic [BYTE_W-1:0]        hwr_data,
    output logic                     hreset_n,
    output logic                     sreset_n,
    output logic [NBYTES*BYTE_W-1:0] cfg_word,
    output logic                     cfg_master,
    output logic                     host_mode,
    output logic [MODE_W-1:0]        mode_sel,
    output logic                     cfg_done,
    output logic                     por_bad
);
    localparam int WORD_W   = NBYTES * BYTE_W;
    localparam int MAX_WAIT = max2(max2(CFG_CYCLES, PLL_CYCLES),
                                   max2(max2(DLL_CYCLES, HRST_CYCLES), SGAP_CYCLES));
    localparam int CNT_W    = $clog2(MAX_WAIT) + 1;

    typedef struct packed {
        seq_st_e           st;
        logic              host;
        logic              master;
        logic              dll_on;
        logic [MODE_W-1:0] mode;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             por_long;
    logic             ld_accept;
    logic             ld_last;

    rstcfg_por_filter #(
        .MIN_LOW(MIN_POR_LOW)
    ) filt_i (
        .clk        (clk),
        .por_n      (por_n),
        .long_enough(por_long)
    );

    rstcfg_timer #(
        .CNT_W(CNT_W)
    ) tmr_i (
        .clk     (clk),
        .clr     (!por_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    assign ld_accept = (r_q.st == ST_HOST);

    rstcfg_host_loader #(
        .BYTE_W(BYTE_W),
        .NBYTES(NBYTES)
    ) ldr_i (
        .clk    (clk),
        .clr    (!por_n),
        .accept (ld_accept),
        .wr_en  (hwr_en),
        .wr_data(hwr_data),
        .word   (cfg_word),
        .last   (ld_last)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!por_n) begin
            r_d.st     = ST_POR;
            r_d.host   = 1'b0;
            r_d.master = 1'b0;
            r_d.dll_on = 1'b0;
            r_d.mode   = '0;
        end else begin
            unique case (r_q.st)
                ST_POR: begin
                    if (!por_long) begin
                        r_d.st = ST_BAD;
                    end else begin
                        r_d.host   = host_en_pin;
                        r_d.dll_on = dll_en;
                        if (host_en_pin) begin
                            r_d.st = ST_HOST;
                        end else begin
                            r_d.master = !cfg_pin;
                            r_d.st     = ST_HWCFG;
                            tmr_load   = 1'b1;
                            tmr_val    = CNT_W'(CFG_CYCLES - 1);
                        end
                    end
                end
                ST_BAD: begin
                    r_d.st = ST_BAD;
                end
                ST_HOST: begin
                    if (ld_last) begin
                        r_d.st   = ST_PLL;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(PLL_CYCLES - 1);
                    end
                end
                ST_HWCFG: begin
                    if (tmr_expired) begin
                        r_d.mode = mode_pins;
                        r_d.st   = ST_PLL;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(PLL_CYCLES - 1);
                    end
                end
                ST_PLL: begin
                    if (tmr_expired) begin
                        tmr_load = 1'b1;
                        if (r_q.dll_on) begin
                            r_d.st  = ST_DLL;
                            tmr_val = CNT_W'(DLL_CYCLES - 1);
                        end else begin
                            r_d.st  = ST_HHOLD;
                            tmr_val = CNT_W'(HRST_CYCLES - 1);
                        end
                    end
                end
                ST_DLL: begin
                    if (tmr_expired) begin
                        r_d.st   = ST_HHOLD;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(HRST_CYCLES - 1);
                    end
                end
                ST_HHOLD: begin
                    if (tmr_expired) begin
                        r_d.st   = ST_SGAP;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(SGAP_CYCLES - 1);
                    end
                end
                ST_SGAP: begin
                    if (tmr_expired) begin
                        r_d.st = ST_DONE;
                    end
                end
                ST_DONE: begin
                    r_d.st = ST_DONE;
                end
                default: begin
                    r_d.st = ST_POR;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign hreset_n   = (r_q.st == ST_SGAP) || (r_q.st == ST_DONE);
    assign sreset_n   = (r_q.st == ST_DONE);
    assign cfg_done   = (r_q.st == ST_DONE);
    assign por_bad    = (r_q.st == ST_BAD);
    assign cfg_master = r_q.master;
    assign host_mode  = r_q.host;
    assign mode_sel   = r_q.mode;

endmodule

// File: rtl/rstcfg_seq_chk.sv
module rstcfg_seq_chk #(
    parameter int MODE_W = 3,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              por_n,
    input logic              hreset_n,
    input logic              sreset_n,
    input logic              cfg_master,
    input logic              host_mode,
    input logic              cfg_done,
    input logic              por_bad,
    input logic [MODE_W-1:0] mode_sel,
    input logic [WORD_W-1:0] cfg_word
);
    // R9
    srst_after_hrst_chk: assert property (@(posedge clk) disable iff (!por_n)
        sreset_n |-> hreset_n);

    // R9
    srst_gap_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sreset_n) |-> ($past(hreset_n, 3) && !$past(hreset_n, 4)));

    // R2
    bad_holds_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        por_bad |-> (!hreset_n && !sreset_n && !cfg_done));

    // R5
    master_only_hw_chk: assert property (@(posedge clk) disable iff (!por_n)
        cfg_master |-> !host_mode);

    // R6
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
        hreset_n |=> $stable(mode_sel));

    // R4
    word_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
        hreset_n |=> $stable(cfg_word));

    // R9
    done_with_srst_chk: assert property (@(posedge clk) disable iff (!por_n)
        cfg_done == sreset_n);

endmodule

bind rstcfg_seq rstcfg_seq_chk #(
    .MODE_W(MODE_W),
    .WORD_W(NBYTES * BYTE_W)
) chk_i (
    .clk       (clk),
    .por_n     (por_n),
    .hreset_n  (hreset_n),
    .sreset_n  (sreset_n),
    .cfg_master(cfg_master),
    .host_mode (host_mode),
    .cfg_done  (cfg_done),
    .por_bad   (por_bad),
    .mode_sel  (mode_sel),
    .cfg_word  (cfg_word)
);

// File: tb/rstcfg_seq_tb_top.sv
module rstcfg_seq_tb_top;
    localparam int CFG_N  = 1024;
    localparam int PLL_N  = 800;
    localparam int DLL_N  = 3073;
    localparam int HRST_N = 512;
    localparam int WD_LIM = 190000;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        host_en_pin = 1'b0;
    logic        cfg_pin = 1'b0;
    logic        dll_en = 1'b0;
    logic [2:0]  mode_pins = 3'd0;
    logic        hwr_en = 1'b0;
    logic [7:0]  hwr_data = 8'd0;
    logic        hreset_n, sreset_n, cfg_master, host_mode, cfg_done, por_bad;
    logic [31:0] cfg_word;
    logic [2:0]  mode_sel;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit over   = 0;

    always #10 clk = ~clk;

    rstcfg_seq dut_i (
        .clk        (clk),
        .por_n      (por_n),
        .host_en_pin(host_en_pin),
        .cfg_pin    (cfg_pin),
        .dll_en     (dll_en),
        .mode_pins  (mode_pins),
        .hwr_en     (hwr_en),
        .hwr_data   (hwr_data),
        .hreset_n   (hreset_n),
        .sreset_n   (sreset_n),
        .cfg_word   (cfg_word),
        .cfg_master (cfg_master),
        .host_mode  (host_mode),
        .mode_sel   (mode_sel),
        .cfg_done   (cfg_done),
        .por_bad    (por_bad)
    );

    task automatic report();
        if (!over) begin
            over = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIM && !over) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WD_LIM);
            report();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) tick();
    endtask

    function automatic int hrst_delay(input bit hw, input bit dll);
        return (hw ? CFG_N : 0) + PLL_N + (dll ? DLL_N : 0) + HRST_N;
    endfunction

    // pulse por_n low for len edges; checks reset state after first low edge
    task automatic por_pulse(input int len, input string tag);
        por_n = 1'b0;
        tick();
        chk({tag, " reset flags"},
            {26'd0, hreset_n, sreset_n, cfg_done, por_bad, cfg_master, host_mode}, 32'd0);
        chk({tag, " reset word"}, cfg_word, 32'd0);
        chk({tag, " reset mode"}, {29'd0, mode_sel}, 32'd0);
        ticks(len - 1);
        por_n = 1'b1;
    endtask

    task automatic wait_srst(input string tag);
        int m = 0;
        chk({tag, " R9 sreset still low at hreset release"}, {31'd0, sreset_n}, 32'd0);
        while (!sreset_n && m < 10) begin
            tick();
            m++;
        end
        chk({tag, " R9 sreset gap"}, m, 3);
        chk({tag, " R9 done"}, {31'd0, cfg_done}, 32'd1);
    endtask

    task automatic run_hw(input logic cfgp, input logic dll, input logic [2:0] modev, input int plen);
        int n = 0;
        int t_exp = hrst_delay(1, dll);
        host_en_pin = 1'b0;
        cfg_pin     = cfgp;
        dll_en      = dll;
        mode_pins   = ~modev;
        por_pulse(plen, "R1");
        while (!hreset_n && n < t_exp + 10) begin
            tick();
            n++;
            if (n == 1) begin
                cfg_pin     = ~cfgp;
                dll_en      = ~dll;
                host_en_pin = 1'b1;
                chk("R3 hardware path", {31'd0, host_mode}, 32'd0);
                chk("R2 accepted pulse", {31'd0, por_bad}, 32'd0);
            end
            if (n == 10) begin
                hwr_en   = 1'b1;
                hwr_data = 8'($urandom);
            end
            if (n == 11) hwr_en = 1'b0;
            if (n == CFG_N - 3) mode_pins = modev;
            if (n == CFG_N + 7) mode_pins = modev ^ 3'b101;
        end
        host_en_pin = 1'b0;
        chk(dll ? "R7 hw hreset delay" : "R8 hw hreset delay no DLL", n, t_exp + 1);
        wait_srst("hw");
        chk("R5 master flag", {31'd0, cfg_master}, {31'd0, ~cfgp});
        chk("R6 mode latched", {29'd0, mode_sel}, {29'd0, modev});
        chk("R4 write ignored in hw mode", cfg_word, 32'd0);
    endtask

    task automatic host_byte(input logic [7:0] b);
        hwr_data = b;
        hwr_en   = 1'b1;
        tick();
        hwr_en   = 1'b0;
    endtask

    task automatic run_host(input logic [31:0] w, input logic dll, input int plen, input int idle);
        int n;
        int t_exp = hrst_delay(0, dll);
        host_en_pin = 1'b1;
        dll_en      = dll;
        cfg_pin     = 1'($urandom);
        por_pulse(plen, "R1");
        tick();
        host_en_pin = 1'b0;
        dll_en      = ~dll;
        chk("R3 host path", {31'd0, host_mode}, 32'd1);
        chk("R5 no master in host", {31'd0, cfg_master}, 32'd0);
        ticks(idle);
        chk("R4 reset held awaiting bytes", {30'd0, hreset_n, sreset_n}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            ticks($urandom % 4);
            host_byte(w[k*8 +: 8]);
            chk("R4 partial word", cfg_word, w & ((32'd1 << (8 * (k + 1))) - 1));
            chk("R4 reset held partial", {31'd0, hreset_n}, 32'd0);
        end
        ticks($urandom % 4);
        host_byte(w[31:24]);
        n = 1;
        while (!hreset_n && n < t_exp + 10) begin
            tick();
            n++;
        end
        chk(dll ? "R7 host hreset delay" : "R8 host hreset delay no DLL", n, t_exp + 1);
        wait_srst("host");
        chk("R4 full word", cfg_word, w);
        host_byte(~w[7:0]);
        tick();
        chk("R4 write after done ignored", cfg_word, w);
    endtask

    task automatic run_bad(input int plen);
        host_en_pin = 1'($urandom);
        por_pulse(plen, "R1");
        ticks(hrst_delay(1, 1) + 20);
        chk("R2 short pulse flagged", {31'd0, por_bad}, 32'd1);
        chk("R2 resets held", {30'd0, hreset_n, sreset_n}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        tick();
        // directed corners
        run_hw(1'b0, 1'b1, 3'b101, 16);
        run_hw(1'b1, 1'b0, 3'b010, 40);
        run_bad(15);
        run_host(32'hA1B2C3D4, 1'b1, 16, 5000);
        run_host(32'h00000001, 1'b0, 20, 0);
        // R10: reassert during hardware lock wait
        host_en_pin = 1'b0;
        dll_en      = 1'b1;
        por_pulse(20, "R1");
        ticks(3000);
        por_pulse(20, "R10 mid hw");
        // R10: reassert during host byte collection
        ticks(5);
        host_en_pin = 1'b1;
        por_pulse(18, "R10 mid hw");
        tick();
        host_byte(8'h5A);
        host_byte(8'hC3);
        chk("R4 two bytes", cfg_word, 32'h0000C35A);
        por_pulse(17, "R10 mid host");
        host_en_pin = 1'b0;
        tick();
        chk("R10 fresh sequence hw", {31'd0, host_mode}, 32'd0);
        ticks(50);
        // random runs
        for (int i = 0; i < 8; i++) begin
            if ($urandom % 2 == 0) begin
                run_hw(1'($urandom), 1'($urandom), 3'($urandom), 16 + int'($urandom % 20));
            end else begin
                run_host($urandom, 1'($urandom), 16 + int'($urandom % 20), int'($urandom % 200));
            end
        end
        report();
    end

endmodule